// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core that completes one instruction per clock. Instruction fetch goes through a dedicated read-only port, and data traffic goes through a separate port, so one instruction can be fetched and one data word accessed in the same cycle. Within a single cycle the core reads the instruction at the program counter, decodes it, reads up to two source registers, computes a result or an effective address, optionally reads or writes data memory, and writes the result back to the register file.

The instruction subset covers register-to-register arithmetic and logic, constant shifts, arithmetic and logic with a 16-bit constant, setting the upper half of a register, and loads and stores of bytes, halfwords and words. The data memory returns whole words only, so the core picks the wanted byte or halfword out of the returned word, with byte 0 of a word on bits 31:24. Control transfer, multiply and divide, traps and pipelining are not part of this block; the program counter simply steps by four each clock.

A system places this core next to an instruction store that answers combinationally on the fetch port and a data store that answers word reads combinationally and takes writes on the falling clock edge of the cycle that presents them.

Top module: `scalar_core`

## Requirements
- R1: `rst` is synchronous and active high; while it is sampled high, `dmem_en` is 0 and no register is written, and in the first cycle after it is released `imem_addr` is 0 and all 31 writable registers read as 0.
- R2: Outside reset, `imem_addr` increases by exactly 4 every clock cycle.
- R3: Register index 0 always reads as 0; an instruction that names it as destination (arithmetic or load) leaves it at 0.
- R4: With bits 31:26 equal to 0x00, function field bits 5:0 of 0x21, 0x23, 0x25, 0x26 and 0x27 write, to the register at bits 15:11, the sum, difference (bits 25:21 operand minus bits 20:16 operand), OR, XOR and NOR of the registers at bits 25:21 and 20:16.
- R5: With bits 31:26 equal to 0x00, function field 0x00 shifts the register at bits 20:16 left by the count at bits 10:6, 0x02 shifts it right inserting zeros, and 0x03 shifts it right inserting copies of bit 31; the result goes to the register at bits 15:11.
- R6: Opcode 0x09 adds the sign-extended 16-bit constant (bits 15:0) to the register at bits 25:21; opcodes 0x0C and 0x0D AND and OR it with the zero-extended constant; each result goes to the register at bits 20:16.
- R7: Opcode 0x0F writes the 16-bit constant into bits 31:16 of the register at bits 20:16 and zeros into bits 15:0.
- R8: Loads (0x20, 0x21, 0x23, 0x24, 0x25) and stores (0x28, 0x29, 0x2B) form the address as the register at bits 25:21 plus the sign-extended constant; a load drives `dmem_en`=1, `dmem_mode`=00 and that address with bits 1:0 cleared; a store drives `dmem_en`=1, the full address, `dmem_mode` 01 for 0x28 (byte), 10 for 0x29 (halfword), 11 for 0x2B (word), and `dmem_wdata` equal to the register at bits 20:16, unshifted (the memory takes its low byte or low halfword).
- R9: Loads write the register at bits 20:16: 0x23 the whole word; 0x20/0x24 the byte selected by address bits 1:0 (0 selects bits 31:24, 3 selects bits 7:0), sign- or zero-extended; 0x21/0x25 the halfword selected by address bit 1 (0 selects bits 31:16), sign- or zero-extended.
- R10: An opcode outside the listed set, or opcode 0x00 with a function value outside the listed set, writes no register and leaves `dmem_en` at 0.
- R11: Any instruction that is neither a load nor a store leaves `dmem_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program counter on rising edge, register writes on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_en | output | 1 | Data port access this cycle |
| dmem_mode | output | 2 | 00 read word, 01 write byte, 10 write halfword, 11 write word |
| dmem_addr | output | 32 | Data byte address (word-aligned for reads) |
| dmem_wdata | output | 32 | Store data, source register value unshifted |
| dmem_rdata | input | 32 | Word read from the aligned address |

## Verification
The assertions take for granted that the instruction port returns a defined word in every cycle after reset and that halfword stores and halfword loads use even addresses and word accesses use addresses with bits 1:0 clear, since the block has no misalignment handling. The stimulus is a fixed program whose base registers and constant offsets are chosen so that every access is naturally aligned and falls inside a small data array, and whose unused instruction slots hold the all-zero word, which is a shift into register 0. A behavioural model in the bench executes the same program in lockstep and compares fetch address, data port controls and store data every cycle, with register contents made visible by storing them.

// File: rtl/score_pkg.sv
package score_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    // primary opcodes, bits 31:26
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_ANDI  = 6'h0c;
    localparam logic [5:0] OP_ORI   = 6'h0d;
    localparam logic [5:0] OP_LUI   = 6'h0f;
    localparam logic [5:0] OP_LB    = 6'h20;
    localparam logic [5:0] OP_LH    = 6'h21;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_LBU   = 6'h24;
    localparam logic [5:0] OP_LHU   = 6'h25;
    localparam logic [5:0] OP_SB    = 6'h28;
    localparam logic [5:0] OP_SH    = 6'h29;
    localparam logic [5:0] OP_SW    = 6'h2b;

    // function codes for the register format, bits 5:0
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;

    // data port modes
    localparam logic [1:0] DM_RD_WORD = 2'b00;
    localparam logic [1:0] DM_WR_BYTE = 2'b01;
    localparam logic [1:0] DM_WR_HALF = 2'b10;
    localparam logic [1:0] DM_WR_WORD = 2'b11;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOR,
        ALU_SLL,
        ALU_SRL,
        ALU_SRA,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [2:0] {
        LD_WORD,
        LD_BYTE_S,
        LD_BYTE_Z,
        LD_HALF_S,
        LD_HALF_Z
    } ld_kind_e;

    typedef struct packed {
        logic             reg_we;
        logic [RIDX-1:0]  dst;
        alu_op_e          alu;
        logic             b_is_imm;
        logic [XLEN-1:0]  imm;
        logic             mem_rd;
        logic             mem_wr;
        logic [1:0]       wmode;
        ld_kind_e         ld;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction

endpackage

// File: rtl/score_regfile.sv
module score_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRD-1:0][AW-1:0] rd_idx,
    output logic [NRD-1:0][W-1:0]  rd_val,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [W-1:0]           wr_val
);

    // entry 0 has no storage; it reads as zero
    logic [W-1:0] cells [1:DEPTH-1];

    always_ff @(negedge clk) begin
        if (rst) begin
            for (int i = 1; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en && wr_idx != '0) begin
            cells[wr_idx] <= wr_val;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        assign rd_val[p] = (rd_idx[p] == '0) ? '0 : cells[rd_idx[p]];
    end

endmodule

// File: rtl/score_decode.sv
module score_decode
    import score_pkg::*;
(
    input  logic [5:0]      op,
    input  logic [RIDX-1:0] rt,
    input  logic [15:0]     imm,
    output ctrl_t           ctl
);

    logic [5:0]      fn;
    logic [RIDX-1:0] rd;

    assign fn = imm[5:0];
    assign rd = imm[15:11];

    always_comb begin
        ctl          = '0;
        ctl.alu      = ALU_ADD;
        ctl.ld       = LD_WORD;
        ctl.wmode    = DM_RD_WORD;
        case (op)
            OP_RTYPE: begin
                ctl.dst    = rd;
                ctl.reg_we = 1'b1;
                case (fn)
                    FN_ADDU: ctl.alu = ALU_ADD;
                    FN_SUBU: ctl.alu = ALU_SUB;
                    FN_OR:   ctl.alu = ALU_OR;
                    FN_XOR:  ctl.alu = ALU_XOR;
                    FN_NOR:  ctl.alu = ALU_NOR;
                    FN_SLL:  ctl.alu = ALU_SLL;
                    FN_SRL:  ctl.alu = ALU_SRL;
                    FN_SRA:  ctl.alu = ALU_SRA;
                    default: ctl.reg_we = 1'b0;
                endcase
            end
            OP_ADDIU: begin
                ctl.reg_we = 1'b1;  ctl.dst = rt;
                ctl.b_is_imm = 1'b1; ctl.imm = sext16(imm);
                ctl.alu = ALU_ADD;
            end
            OP_ANDI: begin
                ctl.reg_we = 1'b1;  ctl.dst = rt;
                ctl.b_is_imm = 1'b1; ctl.imm = zext16(imm);
                ctl.alu = ALU_AND;
            end
            OP_ORI: begin
                ctl.reg_we = 1'b1;  ctl.dst = rt;
                ctl.b_is_imm = 1'b1; ctl.imm = zext16(imm);
                ctl.alu = ALU_OR;
            end
            OP_LUI: begin
                ctl.reg_we = 1'b1;  ctl.dst = rt;
                ctl.b_is_imm = 1'b1; ctl.imm = {imm, 16'h0000};
                ctl.alu = ALU_PASSB;
            end
            OP_LB, OP_LBU, OP_LH, OP_LHU, OP_LW: begin
                ctl.reg_we = 1'b1;  ctl.dst = rt;
                ctl.b_is_imm = 1'b1; ctl.imm = sext16(imm);
                ctl.mem_rd = 1'b1;
                case (op)
                    OP_LB:   ctl.ld = LD_BYTE_S;
                    OP_LBU:  ctl.ld = LD_BYTE_Z;
                    OP_LH:   ctl.ld = LD_HALF_S;
                    OP_LHU:  ctl.ld = LD_HALF_Z;
                    default: ctl.ld = LD_WORD;
                endcase
            end
            OP_SB, OP_SH, OP_SW: begin
                ctl.b_is_imm = 1'b1; ctl.imm = sext16(imm);
                ctl.mem_wr = 1'b1;
                case (op)
                    OP_SB:   ctl.wmode = DM_WR_BYTE;
                    OP_SH:   ctl.wmode = DM_WR_HALF;
                    default: ctl.wmode = DM_WR_WORD;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/score_alu.sv
module score_alu
    import score_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  sh,
    output logic [W-1:0]   y
);

    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_NOR:   y = ~(a | b);
            ALU_SLL:   y = b << sh;
            ALU_SRL:   y = b >> sh;
            ALU_SRA:   y = W'($signed(b) >>> sh);
            default:   y = b;
        endcase
    end

endmodule

// File: rtl/score_loadfmt.sv
module score_loadfmt
    import score_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic [1:0]      ofs,
    input  ld_kind_e        kind,
    output logic [XLEN-1:0] val
);

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    // big-endian lanes: offset 0 is the most significant byte
    always_comb begin
        case (ofs)
            2'd0:    byte_sel = word[31:24];
            2'd1:    byte_sel = word[23:16];
            2'd2:    byte_sel = word[15:8];
            default: byte_sel = word[7:0];
        endcase
        half_sel = ofs[1] ? word[15:0] : word[31:16];
    end

    always_comb begin
        case (kind)
            LD_BYTE_S: val = {{(XLEN-8){byte_sel[7]}}, byte_sel};
            LD_BYTE_Z: val = {{(XLEN-8){1'b0}}, byte_sel};
            LD_HALF_S: val = sext16(half_sel);
            LD_HALF_Z: val = zext16(half_sel);
            default:   val = word;
        endcase
    end

endmodule

// File: rtl/scalar_core.sv
module scalar_core
    import score_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic        dmem_en,
    output logic [1:0]  dmem_mode,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata
);

    localparam int NREG = 1 << RIDX;

    logic [XLEN-1:0]          pc_q;
    ctrl_t                    ctl;
    logic [RIDX-1:0]          rs_idx, rt_idx;
    logic [1:0][RIDX-1:0]     rd_idx;
    logic [1:0][XLEN-1:0]     rd_val;
    logic [XLEN-1:0]          rs_val, rt_val;
    logic [XLEN-1:0]          alu_b, alu_y, ld_val, wb_val;
    logic                     wr_en;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_q + XLEN'(4);
    end

    assign imem_addr = pc_q;
    assign rs_idx    = imem_rdata[25:21];
    assign rt_idx    = imem_rdata[20:16];
    assign rd_idx    = {rt_idx, rs_idx};
    assign rs_val    = rd_val[0];
    assign rt_val    = rd_val[1];

    score_decode u_dec (
        .op  (imem_rdata[31:26]),
        .rt  (rt_idx),
        .imm (imem_rdata[15:0]),
        .ctl (ctl)
    );

    score_regfile #(.W(XLEN), .DEPTH(NREG), .NRD(2)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_idx),
        .rd_val (rd_val),
        .wr_en  (wr_en),
        .wr_idx (ctl.dst),
        .wr_val (wb_val)
    );

    assign alu_b = ctl.b_is_imm ? ctl.imm : rt_val;

    score_alu #(.W(XLEN)) u_alu (
        .op (ctl.alu),
        .a  (rs_val),
        .b  (alu_b),
        .sh (imem_rdata[10:6]),
        .y  (alu_y)
    );

    score_loadfmt u_ldf (
        .word (dmem_rdata),
        .ofs  (alu_y[1:0]),
        .kind (ctl.ld),
        .val  (ld_val)
    );

    assign wb_val     = ctl.mem_rd ? ld_val : alu_y;
    assign wr_en      = ctl.reg_we && !rst;
    assign dmem_en    = (ctl.mem_rd || ctl.mem_wr) && !rst;
    assign dmem_mode  = ctl.mem_wr ? ctl.wmode : DM_RD_WORD;
    assign dmem_addr  = ctl.mem_rd ? {alu_y[XLEN-1:2], 2'b00} : alu_y;
    assign dmem_wdata = rt_val;

endmodule

// File: rtl/score_chk.sv
module score_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_en,
    input logic [1:0]  dmem_mode,
    input logic [31:0] dmem_addr,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val,
    input logic        wr_en
);

    logic [5:0] op, fn;
    logic       is_ldst, is_known;

    assign op = imem_rdata[31:26];
    assign fn = imem_rdata[5:0];
    assign is_ldst = op inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b};
    assign is_known = is_ldst || op inside {6'h09, 6'h0c, 6'h0d, 6'h0f} ||
                      (op == 6'h00 && fn inside {6'h00, 6'h02, 6'h03, 6'h21, 6'h23, 6'h25, 6'h26, 6'h27});

    // R1: reset parks the fetch address at zero
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == 32'h0);

    // R2: steady stepping of the fetch address
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> imem_addr == $past(imem_addr) + 32'd4);

    // R3: register zero reads as zero
    a_r3_zero_read: assert property (@(posedge clk) disable iff (rst)
        rs_idx == 5'd0 |-> rs_val == 32'h0);

    // R8: word reads are aligned
    a_r8_load_aligned: assert property (@(posedge clk) disable iff (rst)
        (dmem_en && dmem_mode == 2'b00) |-> dmem_addr[1:0] == 2'b00);

    // R8: write modes come only from the matching store opcode
    a_r8_write_mode: assert property (@(posedge clk) disable iff (rst)
        (dmem_en && dmem_mode != 2'b00) |->
            ((op == 6'h28 && dmem_mode == 2'b01) || (op == 6'h29 && dmem_mode == 2'b10) ||
             (op == 6'h2b && dmem_mode == 2'b11)));

    // R11: data port idle unless a load or store executes
    a_r11_mem_only_ldst: assert property (@(posedge clk) disable iff (rst)
        dmem_en |-> is_ldst);

    // R10: unrecognised encodings leave all state alone
    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_known |-> (!wr_en && !dmem_en));

endmodule

bind scalar_core score_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_en    (dmem_en),
    .dmem_mode  (dmem_mode),
    .dmem_addr  (dmem_addr),
    .rs_idx     (rs_idx),
    .rs_val     (rs_val),
    .wr_en      (wr_en)
);

// File: tb/sim_scalar_core.sv
`timescale 1ns/1ps
module sim_scalar_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic        dmem_en;
    logic [1:0]  dmem_mode;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;

    always #4 clk = ~clk;  // 125 MHz

    scalar_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_en(dmem_en), .dmem_mode(dmem_mode), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
    );

    logic [31:0] prog [128];
    logic [31:0] dmem [64];   // memory seen by the core
    logic [31:0] rmem [64];   // memory of the reference model
    logic [31:0] rreg [32];
    string       rtag [32];
    logic [31:0] rpc;
    int          pcount = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    assign imem_rdata = prog[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    function automatic logic [31:0] merge(input logic [31:0] w, input logic [1:0] mode,
                                          input logic [1:0] lo, input logic [31:0] d);
        logic [31:0] r;
        r = w;
        case (mode)
            2'b01: r[31 - 8*lo -: 8] = d[7:0];
            2'b10: if (lo[1]) r[15:0] = d[15:0]; else r[31:16] = d[15:0];
            2'b11: r = d;
            default: ;
        endcase
        return r;
    endfunction

    always @(negedge clk)
        if (!rst && dmem_en && dmem_mode != 2'b00)
            dmem[dmem_addr[7:2]] <= merge(dmem[dmem_addr[7:2]], dmem_mode, dmem_addr[1:0], dmem_wdata);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rty(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction
    function automatic logic [31:0] ity(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    task automatic emit(input logic [31:0] w);
        prog[pcount] = w;
        pcount++;
    endtask

    // behavioural execution of one instruction with comparison against the ports
    task automatic step();
        logic [31:0] ins, a, b, ea, val, word;
        logic [5:0]  op, fn;
        int          rs, rt, rd, sh, dst;
        bit          wr, ld, st, known;
        logic [1:0]  md;
        string       tg;
        ins = prog[rpc[8:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]); sh = int'(ins[10:6]);
        a = rreg[rs]; b = rreg[rt];
        ea = a + {{16{ins[15]}}, ins[15:0]};
        wr = 0; ld = 0; st = 0; known = 1; dst = rt; val = 0; md = 2'b00; tg = "R11";
        chk(imem_addr == rpc, "R2", "fetch address", imem_addr, rpc);
        case (op)
            6'h00: begin
                dst = rd; wr = 1;
                case (fn)
                    6'h21: begin val = a + b; tg = "R4"; end
                    6'h23: begin val = a - b; tg = "R4"; end
                    6'h25: begin val = a | b; tg = "R4"; end
                    6'h26: begin val = a ^ b; tg = "R4"; end
                    6'h27: begin val = ~(a | b); tg = "R4"; end
                    6'h00: begin val = b << sh; tg = "R5"; end
                    6'h02: begin val = b >> sh; tg = "R5"; end
                    6'h03: begin
                        val = b;
                        for (int k = 0; k < sh; k++) val = {val[31], val[31:1]};
                        tg = "R5";
                    end
                    default: begin wr = 0; known = 0; end
                endcase
            end
            6'h09: begin wr = 1; val = ea; tg = "R6"; end
            6'h0c: begin wr = 1; val = a & {16'h0, ins[15:0]}; tg = "R6"; end
            6'h0d: begin wr = 1; val = a | {16'h0, ins[15:0]}; tg = "R6"; end
            6'h0f: begin wr = 1; val = {ins[15:0], 16'h0}; tg = "R7"; end
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                wr = 1; ld = 1; tg = "R9";
                word = rmem[ea[7:2]];
                case (op)
                    6'h20: begin val = {24'h0, word[31 - 8*ea[1:0] -: 8]}; val = {{24{val[7]}}, val[7:0]}; end
                    6'h24: val = {24'h0, word[31 - 8*ea[1:0] -: 8]};
                    6'h21: begin val = {16'h0, (ea[1] ? word[15:0] : word[31:16])}; val = {{16{val[15]}}, val[15:0]}; end
                    6'h25: val = {16'h0, (ea[1] ? word[15:0] : word[31:16])};
                    default: val = word;
                endcase
            end
            6'h28: begin st = 1; md = 2'b01; end
            6'h29: begin st = 1; md = 2'b10; end
            6'h2b: begin st = 1; md = 2'b11; end
            default: known = 0;
        endcase
        if (!known) tg = "R10";
        if (ld || st) tg = (ld ? "R8" : "R8");
        chk(dmem_en == (ld || st), tg, "data enable", 32'(dmem_en), 32'(ld || st));
        if (ld) begin
            chk(dmem_mode == 2'b00, "R8", "load mode", 32'(dmem_mode), 32'h0);
            chk(dmem_addr == {ea[31:2], 2'b00}, "R8", "load address", dmem_addr, {ea[31:2], 2'b00});
        end
        if (st) begin
            chk(dmem_mode == md, "R8", "store mode", 32'(dmem_mode), 32'(md));
            chk(dmem_addr == ea, "R8", "store address", dmem_addr, ea);
            chk(dmem_wdata == b, rtag[rt], "store data", dmem_wdata, b);
            rmem[ea[7:2]] = merge(rmem[ea[7:2]], md, ea[1:0], b);
        end
        if (!known) begin
            rtag[rd] = (rd == 0) ? "R3" : "R10";
            rtag[rt] = (rt == 0) ? "R3" : "R10";
        end
        if (wr && dst != 0) begin
            rreg[dst] = val;
            rtag[dst] = tg;
        end
        rpc = rpc + 4;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) prog[i] = 32'h0;
        for (int i = 0; i < 64; i++) begin dmem[i] = 32'h0; rmem[i] = 32'h0; end
        for (int i = 0; i < 32; i++) begin rreg[i] = 32'h0; rtag[i] = (i == 0) ? "R3" : "R1"; end
        // R6/R7 constants
        emit(ity(6'h09, 0, 1, 16'h1234));
        emit(ity(6'h09, 0, 2, 16'hffff));
        emit(ity(6'h0f, 0, 3, 16'hdead));
        emit(ity(6'h0d, 3, 3, 16'hbeef));
        emit(ity(6'h0c, 3, 4, 16'hf0f0));
        emit(ity(6'h09, 2, 13, 16'h8001));
        // R4 register arithmetic and logic
        emit(rty(1, 3, 5, 0, 6'h21));
        emit(rty(1, 3, 6, 0, 6'h23));
        emit(rty(1, 3, 7, 0, 6'h25));
        emit(rty(1, 3, 8, 0, 6'h26));
        emit(rty(1, 3, 9, 0, 6'h27));
        // R5 shifts
        emit(rty(0, 3, 10, 4, 6'h00));
        emit(rty(0, 3, 11, 8, 6'h02));
        emit(rty(0, 3, 12, 8, 6'h03));
        emit(rty(0, 3, 16, 31, 6'h03));
        emit(rty(0, 3, 17, 31, 6'h02));
        emit(rty(0, 1, 18, 0, 6'h00));
        // R3 write to register zero is dropped
        emit(ity(6'h09, 1, 0, 16'h0005));
        emit(rty(1, 3, 0, 0, 6'h21));
        // R10 unknown encodings aimed at r1 and r2
        emit(rty(2, 3, 1, 0, 6'h3f));
        emit(ity(6'h3e, 0, 2, 16'h0044));
        // dump results through word stores at base 0x40
        emit(ity(6'h09, 0, 14, 16'h0040));
        for (int r = 0; r < 19; r++) emit(ity(6'h2b, 14, r, 16'(4 * r)));
        emit(ity(6'h2b, 14, 25, 16'h004c));   // untouched register: R1 reset value
        // R9 sub-word loads from a word at 0x20
        emit(ity(6'h2b, 0, 3, 16'h0020));
        emit(ity(6'h20, 0, 19, 16'h0021));
        emit(ity(6'h24, 0, 20, 16'h0023));
        emit(ity(6'h20, 0, 21, 16'h0020));
        emit(ity(6'h21, 0, 22, 16'h0020));
        emit(ity(6'h25, 0, 23, 16'h0022));
        emit(ity(6'h21, 0, 24, 16'h0022));
        emit(ity(6'h23, 0, 26, 16'h0020));
        emit(ity(6'h24, 0, 27, 16'h0022));
        emit(ity(6'h23, 0, 0, 16'h0020));     // load into register zero
        for (int r = 19; r < 28; r++) emit(ity(6'h2b, 14, r, 16'(4 * r)));
        emit(ity(6'h2b, 14, 0, 16'h0070));
        // R8 byte and halfword stores, read back as words
        emit(ity(6'h28, 0, 1, 16'h0031));
        emit(ity(6'h28, 0, 3, 16'h0033));
        emit(ity(6'h29, 0, 1, 16'h0036));
        emit(ity(6'h29, 0, 2, 16'h0034));
        emit(ity(6'h23, 0, 28, 16'h0030));
        emit(ity(6'h23, 0, 29, 16'h0034));
        emit(ity(6'h2b, 14, 28, 16'h0074));
        emit(ity(6'h2b, 14, 29, 16'h0078));
        // R8 negative offset from a high base
        emit(ity(6'h09, 0, 15, 16'h00f0));
        emit(ity(6'h2b, 15, 5, 16'hfff0));
        emit(ity(6'h23, 15, 30, 16'hfff0));
        emit(ity(6'h2b, 14, 30, 16'h007c));

        // R1 reset behaviour
        repeat (3) begin
            @(posedge clk); #2;
            chk(imem_addr == 32'h0, "R1", "reset fetch address", imem_addr, 32'h0);
            chk(dmem_en == 1'b0, "R1", "reset data enable", 32'(dmem_en), 32'h0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        #1;
        rpc = 32'h0;
        chk(imem_addr == 32'h0, "R1", "first fetch after reset", imem_addr, 32'h0);
        step();
        for (int c = 1; c < 110; c++) begin
            @(posedge clk); #2;
            step();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule